// File: doc/BRIEF.md
# Counted Loop Branch Controller

This block makes the end-of-iteration branch decision for a modulo-scheduled counted loop. It holds two counters: a loop counter for the iterations that still have to start, and an epilogue counter for the drain passes that empty the pipeline once no new iteration starts. It also holds a short chain of stage predicates, one per pipeline stage of the loop body. Each predicate gates the operations of its stage.

Software first loads both counts, then pulses the branch strobe once per pass of the loop body. On each strobe the block does three things. It picks one of four outcomes: keep looping, drain, exit, or ignore. It steps the matching counter and shifts a new first-stage predicate into the chain. For every executed branch it raises a one-cycle rotate pulse, which advances a companion rotating register file. While iterations remain, a 1 enters the chain. During drain a 0 enters instead, so each stage switches off one pass after the stage before it. Only the final drain pass falls through.

Top module: `loop_branch_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises, taken_o and rotate_o are 0 and every bit of pred_o is 0. Both counters are 0.
- R2: A clock edge with load_i high stores loop_cnt_i and epi_cnt_i. It sets pred_o to 1 in bit 0, the first stage, and 0 in all other bits. It raises neither taken_o nor rotate_o.
- R3: A branch strobe with the loop counter above zero decrements the loop counter and leaves the epilogue counter unchanged. It shifts a 1 into pred_o bit 0 and raises taken_o.
- R4: A branch strobe with the loop counter at zero and the epilogue counter above one decrements the epilogue counter. It shifts a 0 into pred_o bit 0 and raises taken_o.
- R5: A branch strobe with the loop counter at zero and the epilogue counter equal to one sets the epilogue counter to zero and shifts a 0 into pred_o bit 0. It raises rotate_o with taken_o low, so the loop falls through.
- R6: On every rotation, bit i of pred_o takes the previous value of bit i-1, for i from 1 to the top bit.
- R7: taken_o, rotate_o and pred_o update on the clock edge that samples branch_i high. rotate_o stays high for exactly that one cycle per executed branch.
- R8: A branch strobe that arrives while both counters are zero raises neither rotate_o nor taken_o, and it leaves pred_o and the counters unchanged.
- R9: When load_i and branch_i are high on the same edge, the load takes effect and the branch is ignored.
- R10: With a loop count of 4 and an epilogue count of 3 (5 elements, 3 stages), exactly 7 branches execute. The first 6 are taken, the 7th falls through, and pred_o ends all zero.
- R11: taken_o is never high unless rotate_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load both counts and restart the predicate chain |
| loop_cnt_i | input | LC_W | Initial loop count |
| epi_cnt_i | input | EC_W | Initial epilogue count |
| branch_i | input | 1 | Loop-branch strobe, one cycle per branch execution |
| taken_o | output | 1 | Branch taken (valid for the cycle after the strobe edge) |
| pred_o | output | STAGES | Stage predicates, bit 0 = first stage |
| rotate_o | output | 1 | One-cycle rotate pulse for the register file |

## Verification
The assertions assume that branch_i and load_i are synchronous, single-cycle strobes. They also assume that loads never ask for counts wider than the ports. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It uses small counts so that the full fill, steady and drain sequence fits in a short table. Strobes that arrive with both counters at zero, and strobes that arrive together with a load, are applied on purpose. They confirm that the guarded state holds still, while the properties remain free of spurious antecedents.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_LOOP  = 2'd1,
    DEC_DRAIN = 2'd2,
    DEC_EXIT  = 2'd3
  } br_dec_e;
endpackage

// File: rtl/lbc_counters.sv
module lbc_counters
  import loop_branch_pkg::*;
#(
  parameter int LC_W = 8,
  parameter int EC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [LC_W-1:0] loop_cnt_i,
  input  logic [EC_W-1:0] epi_cnt_i,
  input  logic            branch_i,
  output br_dec_e         dec_o
);
  localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);
  localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

  logic [LC_W-1:0] lc_q;
  logic [EC_W-1:0] ec_q;
  logic            lc_zero, ec_zero, ec_last;

  assign lc_zero = (lc_q == '0);
  assign ec_zero = (ec_q == '0);
  assign ec_last = (ec_q == EC_ONE);

  always_comb begin
    dec_o = DEC_NONE;
    if (branch_i && !load_i) begin
      if (!lc_zero)     dec_o = DEC_LOOP;
      else if (ec_last) dec_o = DEC_EXIT;
      else if (!ec_zero) dec_o = DEC_DRAIN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q <= '0;
      ec_q <= '0;
    end else if (load_i) begin
      lc_q <= loop_cnt_i;
      ec_q <= epi_cnt_i;
    end else begin
      unique case (dec_o)
        DEC_LOOP:             lc_q <= lc_q - LC_ONE;
        DEC_DRAIN, DEC_EXIT:  ec_q <= ec_q - EC_ONE;
        default: ;
      endcase
    end
  end

  // R3: loop pass counts down the loop counter only
  p_loop_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && !load_i && !lc_zero) |=>
      (lc_q == LC_W'($past(lc_q) - LC_ONE)) && (ec_q == $past(ec_q)));

  // R4 / R5: drain and exit passes count down the epilogue counter
  p_epi_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && !load_i && lc_zero && !ec_zero) |=>
      (ec_q == EC_W'($past(ec_q) - EC_ONE)) && lc_zero);

  // R8: idle strobe freezes both counters
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && lc_zero && ec_zero) |=> (lc_zero && ec_zero));

  // R9: load wins over a simultaneous strobe
  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (lc_q == $past(loop_cnt_i)) && (ec_q == $past(epi_cnt_i)));
endmodule

// File: rtl/lbc_pred_chain.sv
module lbc_pred_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rot_i,
  input  logic              first_i,
  output logic [STAGES-1:0] pred_o
);
  localparam logic [STAGES-1:0] PRED_START = STAGES'(1);

  logic [STAGES-1:0] pred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pred_q[0] <= 1'b0;
    else if (load_i) pred_q[0] <= 1'b1;
    else if (rot_i)  pred_q[0] <= first_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pred_q[s] <= 1'b0;
      else if (load_i) pred_q[s] <= 1'b0;
      else if (rot_i)  pred_q[s] <= pred_q[s-1];
    end
  end

  assign pred_o = pred_q;

  // R6: each rotation moves every predicate up one stage
  p_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && !load_i) |=> (pred_q[STAGES-1:1] == $past(pred_q[STAGES-2:0])));

  // R2: load restarts the chain with only the first stage enabled
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pred_q == PRED_START));

  // R8: no rotation, no load -> predicates hold
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_i && !load_i) |=> $stable(pred_q));
endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import loop_branch_pkg::*;
#(
  parameter int LC_W   = 8,
  parameter int EC_W   = 4,
  parameter int STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LC_W-1:0]   loop_cnt_i,
  input  logic [EC_W-1:0]   epi_cnt_i,
  input  logic              branch_i,
  output logic              taken_o,
  output logic [STAGES-1:0] pred_o,
  output logic              rotate_o
);
  br_dec_e dec;
  logic    rot_d, take_d, first_d;

  lbc_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_counters (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .loop_cnt_i (loop_cnt_i),
    .epi_cnt_i  (epi_cnt_i),
    .branch_i   (branch_i),
    .dec_o      (dec)
  );

  assign rot_d   = (dec != DEC_NONE);
  assign take_d  = (dec == DEC_LOOP) || (dec == DEC_DRAIN);
  assign first_d = (dec == DEC_LOOP);

  lbc_pred_chain #(.STAGES(STAGES)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .rot_i   (rot_d),
    .first_i (first_d),
    .pred_o  (pred_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o  <= 1'b0;
      rotate_o <= 1'b0;
    end else begin
      taken_o  <= take_d;
      rotate_o <= rot_d;
    end
  end

  // R11: taken implies rotate
  p_taken_rot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> rotate_o);

  // R7: no strobe, no pulse on the next cycle
  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branch_i |=> !rotate_o);

  // R9: a load swallows the strobe
  p_load_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !rotate_o && !taken_o);

  // R5: fall-through rotates without taking
  p_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_o && !taken_o) |-> (pred_o[0] == 1'b0));
endmodule

// File: tb/loop_branch_ctrl_test.sv
`timescale 1ns/1ps
module loop_branch_ctrl_test;
  localparam int LC_W = 8;
  localparam int EC_W = 4;
  localparam int ST   = 3;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            load_i = 1'b0;
  logic [LC_W-1:0] loop_cnt_i = '0;
  logic [EC_W-1:0] epi_cnt_i = '0;
  logic            branch_i = 1'b0;
  logic            taken_o, rotate_o;
  logic [ST-1:0]   pred_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  loop_branch_ctrl #(.LC_W(LC_W), .EC_W(EC_W), .STAGES(ST)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .loop_cnt_i(loop_cnt_i),
    .epi_cnt_i(epi_cnt_i), .branch_i(branch_i), .taken_o(taken_o),
    .pred_o(pred_o), .rotate_o(rotate_o)
  );

  typedef struct packed {
    logic            ld;
    logic [LC_W-1:0] lc;
    logic [EC_W-1:0] ec;
    logic            br;
    logic            t;
    logic            r;
    logic [ST-1:0]   p;
    logic [7:0]      req;
  } vec_t;

  localparam int NV = 19;
  // bit 0 of p = first stage
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd4, 4'd3, 1'b0, 1'b0, 1'b0, 3'b001, 8'd2},  // R2 load 4/3
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b011, 8'd3},  // R3
    '{1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 3'b011, 8'd7},  // R7 pulse drops
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b111, 8'd6},  // R6
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b111, 8'd3},
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b111, 8'd3},  // lc 1->0
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b110, 8'd4},  // R4 ec 3->2
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b100, 8'd4},  // R4 ec 2->1
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b1, 3'b000, 8'd5},  // R5 / R10 7th
    '{1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 3'b000, 8'd10},
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b0, 3'b000, 8'd8},  // R8 idle
    '{1'b1, 8'd0, 4'd1, 1'b0, 1'b0, 1'b0, 3'b001, 8'd2},  // load 0/1
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b1, 3'b010, 8'd5},  // R5 exit at once
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b0, 3'b010, 8'd8},  // R8 pred held
    '{1'b1, 8'd1, 4'd2, 1'b1, 1'b0, 1'b0, 3'b001, 8'd9},  // R9 load+branch
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b011, 8'd3},
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1, 3'b110, 8'd4},
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b1, 3'b100, 8'd5},
    '{1'b0, 8'd0, 4'd0, 1'b1, 1'b0, 1'b0, 3'b100, 8'd8}
  };

  task automatic check(input logic t, input logic r, input logic [ST-1:0] p,
                       input int req);
    n_run++;
    if (taken_o !== t || rotate_o !== r || pred_o !== p) begin
      n_fail++;
      $display("FAIL R%0d: taken/rotate/pred = %b/%b/%b expected %b/%b/%b",
               req, taken_o, rotate_o, pred_o, t, r, p);
    end
  endtask

  int taken_cnt;
  int exec_cnt;

  initial begin
    // R1 during reset
    #1;
    check(1'b0, 1'b0, '0, 1);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, '0, 1);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      load_i     = VECS[i].ld;
      loop_cnt_i = VECS[i].lc;
      epi_cnt_i  = VECS[i].ec;
      branch_i   = VECS[i].br;
      @(posedge clk);
      @(negedge clk);
      check(VECS[i].t, VECS[i].r, VECS[i].p, int'(VECS[i].req));
      // R11 taken only with rotate
      n_run++;
      if (taken_o && !rotate_o) begin
        n_fail++;
        $display("FAIL R11: taken=%b rotate=%b expected rotate=1", taken_o, rotate_o);
      end
    end
    load_i = 1'b0; branch_i = 1'b0;

    // R10: count executions of the 4/3 case until fall-through
    load_i = 1'b1; loop_cnt_i = 8'd4; epi_cnt_i = 4'd3;
    @(posedge clk); @(negedge clk);
    load_i = 1'b0;
    taken_cnt = 0; exec_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      branch_i = 1'b1;
      @(posedge clk); @(negedge clk);
      if (rotate_o) exec_cnt++;
      if (taken_o) taken_cnt++;
    end
    branch_i = 1'b0;
    n_run++;
    if (exec_cnt != 7 || taken_cnt != 6 || pred_o != '0) begin
      n_fail++;
      $display("FAIL R10: exec/taken/pred = %0d/%0d/%b expected 7/6/000",
               exec_cnt, taken_cnt, pred_o);
    end

    // R1: reset in mid-loop
    load_i = 1'b1; loop_cnt_i = 8'd5; epi_cnt_i = 4'd2;
    @(posedge clk); @(negedge clk);
    load_i = 1'b0; branch_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rst_ni = 1'b0; branch_i = 1'b0;
    #1;
    check(1'b0, 1'b0, '0, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    branch_i = 1'b1;  // R8: counters cleared by reset, strobe idle
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b0, '0, 8);
    branch_i = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule